// File: doc/BRIEF.md
# Three-Wire Serial Character-Display Writer

This block writes commands and characters to a character display that runs with a 4-bit data bus. The display is reached through an external serial-in, parallel-out shift register, so only three wires leave the chip: a serial data line, a shift clock and an enable strobe. The display's read/write pin is tied to "write". Because of that, the block never polls a busy flag and relies only on fixed, parameterised waits.

A host hands over one byte at a time on a valid/ready handshake, together with a register-select flag. Each byte goes out as two nibble transfers, the high nibble first. For each nibble the block shifts an 8-bit frame into the external register and then pulses the enable strobe while the parallel lines hold still. A raw-nibble flag sends a single nibble instead, which start-up code uses for its early single-nibble commands. After each transfer the block waits before it takes the next request. The wait is longer after clear and home commands.

Top module: `lcdsr_writer`

## Requirements
- R1: While reset is asserted and after its release, `req_ready` is 1 and `sr_clk`, `lcd_en` and `sr_data` are 0.
- R2: Each frame is exactly 8 bits, sent most significant bit first, one bit per rising edge of `sr_clk`. Frame bits [7:4] carry the nibble, bit 3 carries the register-select flag and bits [2:0] are 0.
- R3: `sr_data` does not change while `sr_clk` is high or in the cycle in which `sr_clk` rises.
- R4: Within a frame, every high phase of `sr_clk` and every low phase between two rising edges lasts `HALF_CLKS` clocks.
- R5: `lcd_en` rises `HALF_CLKS` clocks after the eighth `sr_clk` high phase ends. It stays high for `EN_CLKS` clocks. While it is high, `sr_clk` is low and `sr_data` is stable.
- R6: In byte mode (`req_nib` = 0) the block sends two frames with one enable pulse each: first `req_data[7:4]`, then `req_data[3:0]`, both with the same register-select flag.
- R7: In raw-nibble mode (`req_nib` = 1) the block sends a single frame carrying `req_data[3:0]` with one enable pulse. It always uses the normal wait.
- R8: `req_ready` is low from the cycle after acceptance until `WAIT_CLKS` clocks after the last enable pulse falls, and then rises. The wait is counted from the sample where `lcd_en` is first seen low to the sample where `req_ready` is first seen high. `sr_clk` and `lcd_en` are low whenever `req_ready` is high.
- R9: A byte-mode write with register select 0 and data 0x01, 0x02 or 0x03 uses `LONG_WAIT_CLKS` in place of `WAIT_CLKS`. Any other byte uses `WAIT_CLKS`.
- R10: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` falls in the next cycle. A `req_valid` pulse while the block is busy starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a write |
| req_ready | output | 1 | Block can take a write |
| req_data | input | 8 | Byte to write; only [3:0] is used in raw-nibble mode |
| req_rs | input | 1 | Register-select flag (0 command, 1 data) |
| req_nib | input | 1 | 1 sends a single raw nibble |
| sr_data | output | 1 | Serial data to the external shift register |
| sr_clk | output | 1 | Shift clock; the register samples on its rising edge |
| lcd_en | output | 1 | Display enable strobe |

## Verification
Two events can land in the same clock: the end of the inter-command wait, which raises `req_ready`, and the acceptance of a request that the host has held valid throughout the busy period. The bench provokes this by keeping `req_valid` high with a second byte while the first byte is being sent. It then judges three things: `req_ready` is high for exactly one sample, all four frames arrive in order with the right contents, and the measured wait before the handover equals `WAIT_CLKS`. A second, shorter overlap joins the end of the first nibble's enable pulse to the reload of the second frame. It is judged by the frame contents and by the enable pulse width.

// File: rtl/lcdsr_pkg.sv
`timescale 1ns/1ps
package lcdsr_pkg;

  localparam int FRAME_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOW  = 3'd1,
    ST_HIGH = 3'd2,
    ST_GAP  = 3'd3,
    ST_EN   = 3'd4,
    ST_WAIT = 3'd5
  } lcdsr_st_e;

  // nibble in [7:4], select flag in [3], padding zeros in [2:0]
  function automatic logic [FRAME_W-1:0] lcdsr_frame(input logic [3:0] nib, input logic rs);
    return {nib, rs, 3'b000};
  endfunction

endpackage

// File: rtl/lcdsr_tick.sv
`timescale 1ns/1ps
module lcdsr_tick #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/lcdsr_serializer.sv
`timescale 1ns/1ps
module lcdsr_serializer #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] frame,
  input  logic          shift,
  output logic          sdo,
  output logic          last
);

  localparam int BW = (FW > 1) ? $clog2(FW) : 1;

  logic [FW-1:0] sreg_q, sreg_d;
  logic [BW-1:0] left_q, left_d;

  always_comb begin
    sreg_d = sreg_q;
    left_d = left_q;
    if (load) begin
      sreg_d = frame;
      left_d = BW'(FW - 1);
    end else if (shift) begin
      sreg_d = {sreg_q[FW-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      left_q <= '0;
    end else begin
      sreg_q <= sreg_d;
      left_q <= left_d;
    end
  end

  assign sdo  = sreg_q[FW-1];
  assign last = (left_q == '0);

endmodule

// File: rtl/lcdsr_ctrl.sv
`timescale 1ns/1ps
module lcdsr_ctrl
  import lcdsr_pkg::*;
#(
  parameter int CW             = 8,
  parameter int HALF_CLKS      = 4,
  parameter int EN_CLKS        = 8,
  parameter int WAIT_CLKS      = 50,
  parameter int LONG_WAIT_CLKS = 1600
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [7:0]         req_data,
  input  logic               req_rs,
  input  logic               req_nib,
  input  logic               tick_done,
  input  logic               ser_last,
  output logic               req_ready,
  output logic               sr_clk,
  output logic               lcd_en,
  output logic               tick_load,
  output logic [CW-1:0]      tick_val,
  output logic               ser_load,
  output logic [FRAME_W-1:0] ser_frame,
  output logic               ser_shift
);

  lcdsr_st_e  st_q, st_d;
  logic [3:0] lo_q, lo_d;
  logic       rs_q, rs_d;
  logic       second_q, second_d;
  logic       long_q, long_d;
  logic       clk_q, en_q;

  always_comb begin
    st_d      = st_q;
    lo_d      = lo_q;
    rs_d      = rs_q;
    second_d  = second_q;
    long_d    = long_q;
    ser_load  = 1'b0;
    ser_frame = '0;
    ser_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d      = ST_LOW;
          ser_load  = 1'b1;
          ser_frame = lcdsr_frame(req_nib ? req_data[3:0] : req_data[7:4], req_rs);
          lo_d      = req_data[3:0];
          rs_d      = req_rs;
          second_d  = !req_nib;
          long_d    = !req_rs && !req_nib && (req_data[7:2] == 6'd0) && (req_data[1:0] != 2'd0);
        end
      end
      ST_LOW: begin
        if (tick_done) st_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (tick_done) begin
          if (ser_last) begin
            st_d = ST_GAP;
          end else begin
            st_d      = ST_LOW;
            ser_shift = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (tick_done) st_d = ST_EN;
      end
      ST_EN: begin
        if (tick_done) begin
          if (second_q) begin
            st_d      = ST_LOW;
            ser_load  = 1'b1;
            ser_frame = lcdsr_frame(lo_q, rs_q);
            second_d  = 1'b0;
          end else begin
            st_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (tick_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tick_load = (st_d != st_q);
    unique case (st_d)
      ST_LOW, ST_HIGH, ST_GAP: tick_val = CW'(HALF_CLKS - 1);
      ST_EN:                   tick_val = CW'(EN_CLKS - 1);
      ST_WAIT:                 tick_val = long_q ? CW'(LONG_WAIT_CLKS - 1) : CW'(WAIT_CLKS - 1);
      default:                 tick_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      lo_q     <= '0;
      rs_q     <= 1'b0;
      second_q <= 1'b0;
      long_q   <= 1'b0;
      clk_q    <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      st_q     <= st_d;
      lo_q     <= lo_d;
      rs_q     <= rs_d;
      second_q <= second_d;
      long_q   <= long_d;
      clk_q    <= (st_d == ST_HIGH);
      en_q     <= (st_d == ST_EN);
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign sr_clk    = clk_q;
  assign lcd_en    = en_q;

endmodule

// File: rtl/lcdsr_writer.sv
`timescale 1ns/1ps
module lcdsr_writer
  import lcdsr_pkg::*;
#(
  parameter int HALF_CLKS      = 4,
  parameter int EN_CLKS        = 8,
  parameter int WAIT_CLKS      = 50,
  parameter int LONG_WAIT_CLKS = 1600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [7:0] req_data,
  input  logic       req_rs,
  input  logic       req_nib,
  output logic       sr_data,
  output logic       sr_clk,
  output logic       lcd_en
);

  localparam int MAX_A = (HALF_CLKS > EN_CLKS) ? HALF_CLKS : EN_CLKS;
  localparam int MAX_B = (WAIT_CLKS > LONG_WAIT_CLKS) ? WAIT_CLKS : LONG_WAIT_CLKS;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_C + 1);

  logic               tick_load, tick_done;
  logic [CW-1:0]      tick_val;
  logic               ser_load, ser_shift, ser_last;
  logic [FRAME_W-1:0] ser_frame;

  lcdsr_ctrl #(
    .CW(CW), .HALF_CLKS(HALF_CLKS), .EN_CLKS(EN_CLKS),
    .WAIT_CLKS(WAIT_CLKS), .LONG_WAIT_CLKS(LONG_WAIT_CLKS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_data(req_data), .req_rs(req_rs), .req_nib(req_nib),
    .tick_done(tick_done), .ser_last(ser_last),
    .req_ready(req_ready), .sr_clk(sr_clk), .lcd_en(lcd_en),
    .tick_load(tick_load), .tick_val(tick_val),
    .ser_load(ser_load), .ser_frame(ser_frame), .ser_shift(ser_shift)
  );

  lcdsr_tick #(.CW(CW)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(tick_load), .load_val(tick_val), .done(tick_done)
  );

  lcdsr_serializer #(.FW(FRAME_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .frame(ser_frame),
    .shift(ser_shift), .sdo(sr_data), .last(ser_last)
  );

endmodule

// File: rtl/lcdsr_chk.sv
`timescale 1ns/1ps
module lcdsr_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic sr_data,
  input logic sr_clk,
  input logic lcd_en
);

  logic [3:0] rise_cnt;
  logic       clk_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      clk_p    <= 1'b0;
    end else begin
      clk_p <= sr_clk;
      if (lcd_en) begin
        rise_cnt <= '0;
      end else if (sr_clk && !clk_p) begin
        rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_clk |-> $stable(sr_data));

  // R5
  en_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> !sr_clk);

  // R5
  en_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> $stable(sr_data));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!sr_clk && !lcd_en));

  // R10
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> (rise_cnt == 4'd8));

endmodule

bind lcdsr_writer lcdsr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .sr_data(sr_data), .sr_clk(sr_clk), .lcd_en(lcd_en)
);

// File: tb/sim_lcdsr_writer.sv
`timescale 1ns/1ps
module sim_lcdsr_writer;

  localparam int HALF = 3;
  localparam int ENW  = 5;
  localparam int WT   = 20;
  localparam int LWT  = 90;

  logic       clk, rst_n;
  logic       req_valid, req_ready, req_rs, req_nib;
  logic [7:0] req_data;
  logic       sr_data, sr_clk, lcd_en;

  lcdsr_writer #(.HALF_CLKS(HALF), .EN_CLKS(ENW), .WAIT_CLKS(WT), .LONG_WAIT_CLKS(LWT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_rs(req_rs), .req_nib(req_nib),
    .sr_data(sr_data), .sr_clk(sr_clk), .lcd_en(lcd_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // monitor state
  int cyc = 0, bits = 0, nfr = 0;
  int rise_c = 0, fall_c = 0, en_r = 0, en_f = 0, last_gap = -1;
  int bad_high = 0, bad_low = 0, bad_en = 0, bad_settle = 0;
  bit low_ok = 0;
  logic [7:0] cur = '0;
  logic [7:0] frames [8];
  int fbits [8];
  logic p_clk = 0, p_en = 0, p_rdy = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sr_clk && !p_clk) begin
        cur = {cur[6:0], sr_data};
        bits++;
        if (low_ok && (cyc - fall_c != HALF)) bad_low++;
        rise_c = cyc;
      end
      if (!sr_clk && p_clk) begin
        if (cyc - rise_c != HALF) bad_high++;
        fall_c = cyc;
        low_ok = 1;
      end
      if (lcd_en && !p_en) begin
        if (nfr < 8) begin
          frames[nfr] = cur;
          fbits[nfr]  = bits;
        end
        if (cyc - fall_c != HALF) bad_settle++;
        nfr++;
        bits = 0;
        low_ok = 0;
        en_r = cyc;
      end
      if (!lcd_en && p_en) begin
        if (cyc - en_r != ENW) bad_en++;
        en_f = cyc;
      end
      if (req_ready && !p_rdy) last_gap = cyc - en_f;
    end
    p_clk = sr_clk;
    p_en  = lcd_en;
    p_rdy = req_ready;
  end

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic clear_mon();
    nfr = 0; bits = 0; bad_high = 0; bad_low = 0; bad_en = 0; bad_settle = 0; last_gap = -1;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic rs, input logic nib);
    @(negedge clk);
    req_valid = 1; req_data = d; req_rs = rs; req_nib = nib;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    wait_idle();
  endtask

  task automatic t_reset();
    rst_n = 0; req_valid = 0; req_data = 0; req_rs = 0; req_nib = 0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(req_ready), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 sr_clk", int'(sr_clk), 0);
    chk("R1 lcd_en", int'(lcd_en), 0);
    chk("R1 sr_data", int'(sr_data), 0);
  endtask

  task automatic t_byte();
    clear_mon();
    send(8'h5A, 1'b1, 1'b0);
    chk("R6 frame count", nfr, 2);
    chk("R2 high nibble frame", int'(frames[0]), 8'h58);
    chk("R6 low nibble frame", int'(frames[1]), 8'hA8);
    chk("R2 bits frame0", fbits[0], 8);
    chk("R2 bits frame1", fbits[1], 8);
    chk("R4 high phase errors", bad_high, 0);
    chk("R4 low phase errors", bad_low, 0);
    chk("R5 enable width errors", bad_en, 0);
    chk("R5 settle errors", bad_settle, 0);
    chk("R8 wait", last_gap, WT);
  endtask

  task automatic t_long();
    clear_mon();
    send(8'h01, 1'b0, 1'b0);
    chk("R9 clear frame0", int'(frames[0]), 8'h00);
    chk("R9 clear frame1", int'(frames[1]), 8'h10);
    chk("R9 clear wait", last_gap, LWT);
    clear_mon(); send(8'h03, 1'b0, 1'b0);
    chk("R9 home wait", last_gap, LWT);
    clear_mon(); send(8'h02, 1'b0, 1'b0);
    chk("R9 home2 wait", last_gap, LWT);
    clear_mon(); send(8'h01, 1'b1, 1'b0);
    chk("R9 data 01 wait", last_gap, WT);
    clear_mon(); send(8'h04, 1'b0, 1'b0);
    chk("R9 cmd 04 wait", last_gap, WT);
  endtask

  task automatic t_nibble();
    clear_mon();
    send(8'hF3, 1'b0, 1'b1);
    chk("R7 frame count", nfr, 1);
    chk("R7 nibble frame", int'(frames[0]), 8'h30);
    chk("R7 bits", fbits[0], 8);
    chk("R7 wait", last_gap, WT);
    clear_mon();
    send(8'h01, 1'b0, 1'b1);
    chk("R7 nibble 1 frame", int'(frames[0]), 8'h10);
    chk("R7 nibble 1 normal wait", last_gap, WT);
  endtask

  task automatic t_busy_ignore();
    clear_mon();
    @(negedge clk);
    req_valid = 1; req_data = 8'h3C; req_rs = 1; req_nib = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    repeat (10) @(negedge clk);
    req_valid = 1; req_data = 8'hFF; req_rs = 0;
    @(negedge clk);
    req_valid = 0;
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R10 frame count", nfr, 2);
    chk("R10 frame0", int'(frames[0]), 8'h38);
    chk("R10 frame1", int'(frames[1]), 8'hC8);
    chk("R10 still idle", int'(req_ready), 1);
  endtask

  task automatic t_back2back();
    int hi = 0;
    clear_mon();
    @(negedge clk);
    req_valid = 1; req_data = 8'h81; req_rs = 1; req_nib = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_data = 8'h7E; req_rs = 0;
    while (!req_ready) @(negedge clk);
    hi = 1;
    @(negedge clk);
    req_valid = 0;
    if (req_ready) hi++;
    chk("R8 wait before handover", last_gap, WT);
    wait_idle();
    chk("R10 ready single sample", hi, 1);
    chk("R6 four frames", nfr, 4);
    chk("R6 b2b frame0", int'(frames[0]), 8'h88);
    chk("R6 b2b frame1", int'(frames[1]), 8'h18);
    chk("R6 b2b frame2", int'(frames[2]), 8'h70);
    chk("R6 b2b frame3", int'(frames[3]), 8'hE0);
    chk("R5 b2b enable widths", bad_en, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_byte();
    t_long();
    t_nibble();
    t_busy_ignore();
    t_back2back();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule